// File: doc/BRIEF.md
# Flash command interface and status

This block sits between a flash device's host bus and its internal operation sequencer. It takes host write cycles, decodes two-step commands (a setup write followed by a confirm write to the same block), and hands each accepted block-erase or blank-check job to the sequencer. It holds the status register and sends either that register or array data back on host reads, depending on the current read mode.

A job is refused when the target block's lock bit is set or when the programming supply is not valid. A confirm that does not match the pending setup is recorded as a sequence error. Error flags are sticky and are cleared only by the clear-status command. While a blank check runs, the host can only read status. While an erase runs, the host can only switch read modes. The job request to the sequencer is a valid/ready stream. The request is presented with `op_valid` and holds steady until the sequencer takes it with `op_ready`. The sequencer reports the end of a job with a single-cycle `seq_done` pulse.

Top module: `flash_cmd_if`

## Requirements
- R1: A write of 0x20 (erase setup) or 0xBC (blank-check setup), followed by a write of 0xD0 whose block field (address bits [ADDR_W-1 -: log2(NBLK)]) matches the setup, starts a job, provided the block is unlocked and `vpp_ok` is high. On the next cycle `op_valid` is 1, `op_kind` is 0 for erase or 1 for blank check, and `op_block` is the block.
- R2: While `op_valid` is 1 and `op_ready` is 0, `op_valid`, `op_kind` and `op_block` hold their values. The request drops in the cycle after `op_ready` is seen high.
- R3: A read in status mode returns {zeros, SR[7:0]} at any address. A setup write, a confirm write or 0x70 selects status mode. 0xFF selects array mode. The mode is array mode after reset.
- R4: SR bit 7 is 0 from the confirm that starts a job until a `seq_done` pulse is accepted, and 1 otherwise. `seq_done` is ignored while no job is running or while the request has not yet been accepted. After reset SR is 0x80.
- R5: A `seq_done` pulse with `seq_fail` high sets SR bit 5.
- R6: A matching confirm while `vpp_ok` is 0 sets SR bit 3 and starts no job.
- R7: A matching confirm to a locked block (`lock_bits[block]`=1) with a valid supply sets SR bit 1 and starts no job.
- R8: Any write after a setup that is not 0xD0 to the same block sets SR bits 4 and 5, starts no job, and selects status mode.
- R9: SR bit 0 reads 1 only while an erase is running and the read address falls in the erasing block.
- R10: While a blank check runs, all writes are ignored and every read returns status.
- R11: While an erase runs, only 0x70 and 0xFF take effect. Setup, confirm and clear writes are ignored.
- R12: SR bits 5, 4, 3 and 1 accumulate over jobs and are cleared only by a 0x50 write while idle with no setup pending.
- R13: With `bus_ce` low, writes and reads are ignored, and a running job still completes.
- R14: A read (`bus_re` and `bus_ce` high) gives `rd_valid` on the next cycle, with data taken from the state before that edge. In array mode the data is `array_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ce | input | 1 | Chip enable for host cycles |
| bus_we | input | 1 | Host write strobe |
| bus_re | input | 1 | Host read strobe |
| bus_addr | input | ADDR_W | Host address; the top bits select the block |
| bus_wdata | input | DATA_W | Write data; the command is the low byte |
| array_rdata | input | DATA_W | Array contents at `bus_addr`, valid in the same cycle |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DATA_W | Status word or array data |
| lock_bits | input | NBLK | Lock bit per block |
| vpp_ok | input | 1 | Programming supply above lockout |
| op_valid | output | 1 | Job request valid |
| op_ready | input | 1 | Sequencer takes the job |
| op_kind | output | 1 | 0 erase, 1 blank check |
| op_block | output | log2(NBLK) | Target block |
| seq_done | input | 1 | Job finished pulse |
| seq_fail | input | 1 | Job failed, qualified by `seq_done` |

## Verification
A host read can land on the same edge as a confirm write. The read must report the status from before that edge: the device is still ready, and the new job does not show yet. This is provoked by asserting read and write strobes together on the confirm. A `seq_done` pulse can also coincide with a 0xFF write during an erase. Here both must take effect: the job retires and the mode switches to array. A following array read and a later status read judge the outcome. A behavioural model in the bench follows every edge and checks both cases.

// File: rtl/fci_pkg.sv
package fci_pkg;
  localparam logic [7:0] OPC_ERASE_SETUP = 8'h20;
  localparam logic [7:0] OPC_BLANK_SETUP = 8'hBC;
  localparam logic [7:0] OPC_CONFIRM     = 8'hD0;
  localparam logic [7:0] OPC_CLR_STAT    = 8'h50;
  localparam logic [7:0] OPC_RD_STAT     = 8'h70;
  localparam logic [7:0] OPC_RD_ARRAY    = 8'hFF;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_ERASE_SETUP,
    CMD_BLANK_SETUP,
    CMD_CONFIRM,
    CMD_CLEAR,
    CMD_RD_STAT,
    CMD_RD_ARRAY
  } cmd_e;

  typedef enum logic {OPK_ERASE = 1'b0, OPK_BLANK = 1'b1} opk_e;
  typedef enum logic {MODE_ARRAY = 1'b0, MODE_STATUS = 1'b1} rmode_e;

  typedef struct packed {
    logic fail;
    logic seq_err;
    logic vpp_err;
    logic lock_err;
  } err_t;
endpackage

// File: rtl/fci_decode.sv
module fci_decode
  import fci_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              bus_ce,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              wr_fire,
  output cmd_e              cmd
);
  logic [7:0] opc;

  assign opc     = bus_wdata[7:0];
  assign wr_fire = bus_ce & bus_we;

  generate
    if (DATA_W > 8) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^bus_wdata[DATA_W-1:8];
    end
  endgenerate

  always_comb begin
    unique case (opc)
      OPC_ERASE_SETUP: cmd = CMD_ERASE_SETUP;
      OPC_BLANK_SETUP: cmd = CMD_BLANK_SETUP;
      OPC_CONFIRM:     cmd = CMD_CONFIRM;
      OPC_CLR_STAT:    cmd = CMD_CLEAR;
      OPC_RD_STAT:     cmd = CMD_RD_STAT;
      OPC_RD_ARRAY:    cmd = CMD_RD_ARRAY;
      default:         cmd = CMD_NONE;
    endcase
  end
endmodule

// File: rtl/fci_ctrl.sv
module fci_ctrl
  import fci_pkg::*;
#(
  parameter int NBLK  = 8,
  parameter int BLK_W = $clog2(NBLK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_fire,
  input  cmd_e             cmd,
  input  logic [BLK_W-1:0] wr_blk,
  input  logic [NBLK-1:0]  lock_bits,
  input  logic             vpp_ok,
  input  logic             op_ready,
  input  logic             seq_done,
  input  logic             seq_fail,
  output logic             op_valid,
  output opk_e             op_kind,
  output logic [BLK_W-1:0] op_block,
  output logic             busy,
  output rmode_e           mode,
  output err_t             err_set,
  output logic             clr_req
);
  logic             pend_q;
  opk_e             pend_kind_q;
  logic [BLK_W-1:0] pend_blk_q;
  logic             busy_q;
  logic             opv_q;
  opk_e             kind_q;
  logic [BLK_W-1:0] blk_q;
  rmode_e           mode_q;

  logic arm;
  logic confirm_ok;
  logic blk_locked;
  logic start;
  logic done_acc;

  assign arm        = wr_fire & ~busy_q & pend_q;
  assign confirm_ok = (cmd == CMD_CONFIRM) && (wr_blk == pend_blk_q);
  assign blk_locked = lock_bits[wr_blk];
  assign start      = arm & confirm_ok & vpp_ok & ~blk_locked;
  assign done_acc   = busy_q & ~opv_q & seq_done;

  always_comb begin
    err_set.seq_err  = arm & ~confirm_ok;
    err_set.fail     = (arm & ~confirm_ok) | (done_acc & seq_fail);
    err_set.vpp_err  = arm & confirm_ok & ~vpp_ok;
    err_set.lock_err = arm & confirm_ok & vpp_ok & blk_locked;
  end

  assign clr_req = wr_fire & ~busy_q & ~pend_q & (cmd == CMD_CLEAR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_kind_q <= OPK_ERASE;
      pend_blk_q  <= '0;
      busy_q      <= 1'b0;
      opv_q       <= 1'b0;
      kind_q      <= OPK_ERASE;
      blk_q       <= '0;
      mode_q      <= MODE_ARRAY;
    end else begin
      if (opv_q && op_ready) opv_q <= 1'b0;
      if (done_acc) busy_q <= 1'b0;
      if (wr_fire) begin
        if (busy_q) begin
          if (kind_q == OPK_ERASE) begin
            if (cmd == CMD_RD_STAT)       mode_q <= MODE_STATUS;
            else if (cmd == CMD_RD_ARRAY) mode_q <= MODE_ARRAY;
          end
        end else if (pend_q) begin
          pend_q <= 1'b0;
          mode_q <= MODE_STATUS;
          if (start) begin
            busy_q <= 1'b1;
            opv_q  <= 1'b1;
            kind_q <= pend_kind_q;
            blk_q  <= pend_blk_q;
          end
        end else begin
          case (cmd)
            CMD_ERASE_SETUP, CMD_BLANK_SETUP: begin
              pend_q      <= 1'b1;
              pend_kind_q <= (cmd == CMD_BLANK_SETUP) ? OPK_BLANK : OPK_ERASE;
              pend_blk_q  <= wr_blk;
              mode_q      <= MODE_STATUS;
            end
            CMD_RD_STAT:  mode_q <= MODE_STATUS;
            CMD_RD_ARRAY: mode_q <= MODE_ARRAY;
            default: ;
          endcase
        end
      end
    end
  end

  assign op_valid = opv_q;
  assign op_kind  = kind_q;
  assign op_block = blk_q;
  assign busy     = busy_q;
  assign mode     = mode_q;
endmodule

// File: rtl/fci_status.sv
module fci_status
  import fci_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  err_t       err_set,
  input  logic       clr_req,
  input  logic       busy,
  input  logic       blk_hit,
  output logic [7:0] sr
);
  err_t err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= (clr_req ? err_t'('0) : err_q) | err_set;
  end

  assign sr = {~busy, 1'b0, err_q.fail, err_q.seq_err,
               err_q.vpp_err, 1'b0, err_q.lock_err, blk_hit};
endmodule

// File: rtl/fci_rdport.sv
module fci_rdport #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_fire,
  input  logic              status_sel,
  input  logic [7:0]        sr,
  input  logic [DATA_W-1:0] array_rdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] stat_word;

  generate
    if (DATA_W > 8) begin : g_wide
      assign stat_word = {{(DATA_W-8){1'b0}}, sr};
    end else begin : g_narrow
      assign stat_word = sr[DATA_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_fire;
      if (rd_fire) rd_data <= status_sel ? stat_word : array_rdata;
    end
  end
endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import fci_pkg::*;
#(
  parameter int NBLK   = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  localparam int BLK_W = $clog2(NBLK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_ce,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] array_rdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic [NBLK-1:0]   lock_bits,
  input  logic              vpp_ok,
  output logic              op_valid,
  input  logic              op_ready,
  output logic              op_kind,
  output logic [BLK_W-1:0]  op_block,
  input  logic              seq_done,
  input  logic              seq_fail
);
  logic             wr_fire;
  cmd_e             cmd;
  logic [BLK_W-1:0] addr_blk;
  opk_e             kind;
  logic             busy;
  rmode_e           mode;
  err_t             err_set;
  logic             clr_req;
  logic             blk_hit;
  logic             status_sel;
  logic [7:0]       sr;
  logic             unused_addr_lo;

  assign addr_blk       = bus_addr[ADDR_W-1 -: BLK_W];
  assign unused_addr_lo = ^bus_addr[ADDR_W-BLK_W-1:0];

  fci_decode #(.DATA_W(DATA_W)) u_dec (
    .bus_ce    (bus_ce),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .wr_fire   (wr_fire),
    .cmd       (cmd)
  );

  fci_ctrl #(.NBLK(NBLK), .BLK_W(BLK_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_fire   (wr_fire),
    .cmd       (cmd),
    .wr_blk    (addr_blk),
    .lock_bits (lock_bits),
    .vpp_ok    (vpp_ok),
    .op_ready  (op_ready),
    .seq_done  (seq_done),
    .seq_fail  (seq_fail),
    .op_valid  (op_valid),
    .op_kind   (kind),
    .op_block  (op_block),
    .busy      (busy),
    .mode      (mode),
    .err_set   (err_set),
    .clr_req   (clr_req)
  );

  assign op_kind    = kind;
  assign blk_hit    = busy && (kind == OPK_ERASE) && (addr_blk == op_block);
  assign status_sel = (mode == MODE_STATUS) || (busy && (kind == OPK_BLANK));

  fci_status u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .err_set (err_set),
    .clr_req (clr_req),
    .busy    (busy),
    .blk_hit (blk_hit),
    .sr      (sr)
  );

  fci_rdport #(.DATA_W(DATA_W)) u_rd (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_fire     (bus_re & bus_ce),
    .status_sel  (status_sel),
    .sr          (sr),
    .array_rdata (array_rdata),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data)
  );
endmodule

// File: rtl/fci_sva.sv
module fci_sva #(
  parameter int NBLK   = 8,
  parameter int DATA_W = 16,
  localparam int BLK_W = $clog2(NBLK)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_ce,
  input logic              bus_re,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic [NBLK-1:0]   lock_bits,
  input logic              vpp_ok,
  input logic              op_valid,
  input logic              op_ready,
  input logic              op_kind,
  input logic [BLK_W-1:0]  op_block,
  input logic              busy_i
);
  logic [NBLK-1:0] lock_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_prev <= '0;
    else        lock_prev <= lock_bits;
  end

  a_r2_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !op_ready |=> op_valid && $stable(op_block) && $stable(op_kind));

  a_r6_start_needs_supply: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_valid) |-> $past(vpp_ok));

  a_r7_start_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_valid) |-> !lock_prev[op_block]);

  a_r14_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re && bus_ce |=> rd_valid);

  a_r13_no_read_without_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_re && bus_ce) |=> !rd_valid);

  a_r10_blank_reads_status: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i && op_kind && bus_re && bus_ce |=> !rd_data[7] && (rd_data[DATA_W-1:8] == '0));
endmodule

bind flash_cmd_if fci_sva #(.NBLK(NBLK), .DATA_W(DATA_W)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_ce    (bus_ce),
  .bus_re    (bus_re),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .lock_bits (lock_bits),
  .vpp_ok    (vpp_ok),
  .op_valid  (op_valid),
  .op_ready  (op_ready),
  .op_kind   (op_kind),
  .op_block  (op_block),
  .busy_i    (busy)
);

// File: tb/flash_cmd_if_tb.sv
`timescale 1ns/1ps
module flash_cmd_if_tb;
  localparam int NBLK = 8;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;
  localparam int BSH = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_ce = 1'b1, bus_we = 1'b0, bus_re = 1'b0;
  logic [15:0] bus_addr = '0, bus_wdata = '0;
  logic [15:0] array_rdata;
  logic rd_valid;
  logic [15:0] rd_data;
  logic [7:0] lock_bits = '0;
  logic vpp_ok = 1'b1;
  logic op_valid, op_ready = 1'b0, op_kind;
  logic [2:0] op_block;
  logic seq_done = 1'b0, seq_fail = 1'b0;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;
  assign array_rdata = bus_addr ^ 16'h5A3C;

  flash_cmd_if #(.NBLK(NBLK), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_ce(bus_ce), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .array_rdata(array_rdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .lock_bits(lock_bits), .vpp_ok(vpp_ok),
    .op_valid(op_valid), .op_ready(op_ready), .op_kind(op_kind), .op_block(op_block),
    .seq_done(seq_done), .seq_fail(seq_fail));

  // behavioural reference model
  int m_mode, m_pend, m_pkind, m_pblk, m_busy, m_kind, m_blk, m_opp;
  int m_fail, m_seq, m_vpp, m_lock, m_rdv;
  logic [15:0] m_rdd;
  int b0, o0, wb, ab, c;

  function automatic logic [15:0] stat_word(int addr_blk);
    logic [7:0] s;
    s = {m_busy == 0, 1'b0, m_fail != 0, m_seq != 0, m_vpp != 0, 1'b0, m_lock != 0,
         (m_busy != 0) && (m_kind == 0) && (addr_blk == m_blk)};
    return {8'h00, s};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_pend = 0; m_pkind = 0; m_pblk = 0; m_busy = 0; m_kind = 0;
      m_blk = 0; m_opp = 0; m_fail = 0; m_seq = 0; m_vpp = 0; m_lock = 0;
      m_rdv = 0; m_rdd = '0;
    end else begin
      ab = int'(bus_addr) >> BSH;
      wb = ab;
      c  = int'(bus_wdata[7:0]);
      m_rdv = int'(bus_re && bus_ce);
      if (m_rdv != 0)
        m_rdd = (m_mode == 1 || (m_busy != 0 && m_kind == 1)) ? stat_word(ab) : array_rdata;
      b0 = m_busy; o0 = m_opp;
      if (o0 != 0 && op_ready) m_opp = 0;
      if (b0 != 0 && o0 == 0 && seq_done) begin
        m_busy = 0;
        if (seq_fail) m_fail = 1;
      end
      if (bus_we && bus_ce) begin
        if (b0 != 0) begin
          if (m_kind == 0 && c == 'h70) m_mode = 1;
          if (m_kind == 0 && c == 'hFF) m_mode = 0;
        end else if (m_pend != 0) begin
          m_pend = 0; m_mode = 1;
          if (c == 'hD0 && wb == m_pblk) begin
            if (!vpp_ok) m_vpp = 1;
            else if (lock_bits[wb]) m_lock = 1;
            else begin m_busy = 1; m_opp = 1; m_kind = m_pkind; m_blk = m_pblk; end
          end else begin
            m_seq = 1; m_fail = 1;
          end
        end else begin
          if (c == 'h20 || c == 'hBC) begin
            m_pend = 1; m_pkind = (c == 'hBC) ? 1 : 0; m_pblk = wb; m_mode = 1;
          end else if (c == 'h50) begin
            m_fail = 0; m_seq = 0; m_vpp = 0; m_lock = 0;
          end else if (c == 'h70) m_mode = 1;
          else if (c == 'hFF) m_mode = 0;
        end
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R1/R2 op_valid", 32'(op_valid), 32'(m_opp != 0));
      if (m_opp != 0) begin
        chk("R1 op_kind", 32'(op_kind), 32'(m_kind));
        chk("R1 op_block", 32'(op_block), 32'(m_blk));
      end
      chk("R14 rd_valid", 32'(rd_valid), 32'(m_rdv != 0));
      if (m_rdv != 0) chk("R3/R14 rd_data", 32'(rd_data), 32'(m_rdd));
    end
  end

  task automatic wr_ce(logic [15:0] a, logic [7:0] d, logic ce);
    bus_addr = a; bus_wdata = {8'h00, d}; bus_we = 1'b1; bus_ce = ce;
    @(negedge clk);
    bus_we = 1'b0; bus_ce = 1'b1;
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    wr_ce(a, d, 1'b1);
  endtask

  task automatic rd(logic [15:0] a, output logic [15:0] d);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    d = rd_data; bus_re = 1'b0;
  endtask

  task automatic wrrd(logic [15:0] a, logic [7:0] wd, output logic [15:0] d);
    bus_addr = a; bus_wdata = {8'h00, wd}; bus_we = 1'b1; bus_re = 1'b1;
    @(negedge clk);
    d = rd_data; bus_we = 1'b0; bus_re = 1'b0;
  endtask

  task automatic accept();
    op_ready = 1'b1;
    @(negedge clk);
    op_ready = 1'b0;
  endtask

  task automatic pulse_done(logic f);
    seq_done = 1'b1; seq_fail = f;
    @(negedge clk);
    seq_done = 1'b0; seq_fail = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R14 reset rd_valid", 32'(rd_valid), 0);
    chk("R4 reset op_valid", 32'(op_valid), 0);
    rd(16'h0123, d); chk("R14 array read after reset", 32'(d), 32'h5B1F);
    wr(16'h0000, 8'h70);
    rd(16'h0000, d); chk("R3 R4 reset status", 32'(d), 32'h0080);

    // erase on block 2
    wr(16'h4000, 8'h20);
    wr(16'h4000, 8'hD0);
    chk("R1 erase request", {op_valid, op_kind, op_block}, 32'b1_0_010);
    rd(16'h4010, d); chk("R9 busy block hit", 32'(d), 32'h0001);
    rd(16'h0000, d); chk("R9 other block", 32'(d), 32'h0000);
    pulse_done(1'b0);
    rd(16'h4000, d); chk("R4 done before accept ignored", 32'(d), 32'h0001);
    wr(16'h6000, 8'h20);
    wr(16'h0000, 8'h50);
    chk("R2 request held", {op_valid, op_block}, 32'b1_010);
    wr(16'h0000, 8'hFF);
    rd(16'h0040, d); chk("R11 array mode during erase", 32'(d), 32'h5A7C);
    wr(16'h0000, 8'h70);
    accept();
    wr_ce(16'h0000, 8'hFF, 1'b0);
    bus_ce = 1'b0; pulse_done(1'b0); bus_ce = 1'b1;
    bus_ce = 1'b0; rd(16'h0000, d); bus_ce = 1'b1;
    chk("R13 read ignored with ce low", 32'(rd_valid), 0);
    rd(16'h0000, d); chk("R13 erase completes, write ignored", 32'(d), 32'h0080);

    // blank check on block 1
    wr(16'h2000, 8'hBC);
    wr(16'h2000, 8'hD0);
    chk("R11 no stale setup; R1 blank request", {op_valid, op_kind, op_block}, 32'b1_1_001);
    wr(16'h0000, 8'hFF);
    rd(16'h2000, d); chk("R10 status only during blank", 32'(d), 32'h0000);
    accept();
    pulse_done(1'b1);
    rd(16'h2000, d); chk("R5 fail flag", 32'(d), 32'h00A0);

    // supply error, sticky
    vpp_ok = 1'b0;
    wr(16'h8000, 8'h20);
    wr(16'h8000, 8'hD0);
    chk("R6 no request", 32'(op_valid), 0);
    vpp_ok = 1'b1;
    rd(16'h8000, d); chk("R6 R12 supply error accumulates", 32'(d), 32'h00A8);
    wr(16'h0000, 8'h50);
    rd(16'h0000, d); chk("R12 clear", 32'(d), 32'h0080);

    // locked block
    lock_bits = 8'h08;
    wr(16'h6000, 8'h20);
    wr(16'h6000, 8'hD0);
    chk("R7 no request", 32'(op_valid), 0);
    lock_bits = 8'h00;
    rd(16'h6000, d); chk("R7 lock abort", 32'(d), 32'h0082);
    wr(16'h0000, 8'h50);

    // sequence errors
    wr(16'h8000, 8'h20);
    wr(16'hA000, 8'hD0);
    rd(16'h0000, d); chk("R8 block mismatch", 32'(d), 32'h00B0);
    wr(16'h0000, 8'hFF);
    rd(16'h0000, d); chk("R3 array mode", 32'(d), 32'h5A3C);
    wr(16'h8000, 8'hBC);
    wr(16'h8000, 8'h55);
    chk("R8 no request", 32'(op_valid), 0);
    rd(16'h1234, d); chk("R8 data mismatch", 32'(d), 32'h00B0);
    wr(16'h0000, 8'h50);

    pulse_done(1'b1);
    rd(16'h0000, d); chk("R4 idle done ignored", 32'(d), 32'h0080);

    // same-cycle cases
    wr(16'hC000, 8'h20);
    wrrd(16'hC000, 8'hD0, d);
    chk("R4 read with confirm sees old state", 32'(d), 32'h0080);
    chk("R1 request block 6", {op_valid, op_block}, 32'b1_110);
    accept();
    bus_addr = 16'h0000; bus_wdata = 16'h00FF; bus_we = 1'b1; seq_done = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; seq_done = 1'b0;
    rd(16'h0000, d); chk("R11 mode switch with done", 32'(d), 32'h5A3C);
    wr(16'h0000, 8'h70);
    rd(16'h0000, d); chk("R4 done with write retires", 32'(d), 32'h0080);

    repeat (3) @(negedge clk);
    summary();
  end
endmodule